// File: doc/BRIEF.md
# Bus-Mapped SPI Master Controller

This block is an SPI master that sits on an 8-bit microprocessor bus. A host selects it with an active-low chip select, gives a read/write strobe and two address bits, and reaches four byte registers: the transfer data, a control register that reads back as status, the serial clock divisor, and a slave-select register. Writing a byte into the data register sends it out on MOSI, most significant bit first. At the same time a byte comes in from MISO. Any of the four clock-polarity and clock-phase combinations can be used.

When a byte finishes, the host learns of it in one of two ways. It can poll the done and busy flags, or it can let an active-low interrupt line tell it. Reading the received byte acknowledges both. The eight select lines follow the slave-select register bit for bit. When the interface is disabled, a drive-enable output goes low so that the pads release MOSI, SCLK and the select lines.

The bus side is sampled on the rising edge of the bus phase clock. Read data is combinational from the address. A register write, or the acknowledging side effect of a data read, takes effect at the clock edge that ends the access.

Top module: `spi_bus_master`

## Requirements
- R1: The address bits select the registers: 00 data, 01 control on write and status on read, 10 divisor, 11 slave select. The divisor and slave-select registers read back what was written. Control bits are written and read at fixed positions: bit 6 interrupt enable, bit 5 interface enable, bit 2 clock polarity, bit 1 clock phase.
- R2: Synchronous reset clears all of the following: control, divisor, slave-select and received-data registers, and the done and interrupt flags. After reset every register reads 0, irq_n is 1 and drive_en is 0.
- R3: A data write while the interface is enabled and idle starts a transfer. Status bit 3 (busy) is 1 from the cycle after the write edge. It stays 1 for exactly 16×(divisor+1) cycles.
- R4: One transfer exchanges 8 bits, most significant bit first, in each of the four modes. The slave receives the written byte. A later data read returns the byte that came in on MISO.
- R5: SCLK rests at the polarity level whenever no transfer runs. During a transfer it toggles exactly 16 times, and each half period lasts divisor+1 cycles.
- R6: Status bit 4 (done) sets when a transfer completes. A data read clears both the done flag and the interrupt flag (status bit 7).
- R7: When interrupt enable is set, completion sets status bit 7 and drives irq_n low. When interrupt enable is clear, neither happens.
- R8: With interface enable clear, drive_en is 0 and a data write starts no transfer. Busy stays 0 and the received byte is unchanged.
- R9: A data write while busy is ignored. The transfer in progress keeps its byte and its timing.
- R10: The ss output equals the slave-select register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus phase clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus |
| irq_n | output | 1 | Active-low interrupt request |
| miso | input | 1 | Serial data from slave |
| mosi | output | 1 | Serial data to slave |
| sclk | output | 1 | Serial clock |
| ss | output | 8 | Slave-select lines |
| drive_en | output | 1 | Pad enable for mosi, sclk and ss |

## Verification
Busy becomes visible in the first cycle after the data-write edge. It is then held for 16×(divisor+1) cycles, or one cycle fewer when the bench places an ignored second write on the very next edge, so the bench counts busy cycles exactly. The done flag, the interrupt flag and irq_n change on the same edge that clears busy. The acknowledgement from a data read lands on the edge that ends that read. All outputs are sampled at the falling clock edge, with status held on the bus while the bench counts. The bench counts SCLK toggles per transfer and checks the rest level in the sample after completion.

// File: rtl/spi_bus_pkg.sv
package spi_bus_pkg;

    localparam int BUS_W  = 8;
    localparam int XFER_N = 8;

    typedef enum logic [1:0] {
        REG_DATA = 2'b00,
        REG_CTRL = 2'b01,
        REG_DIV  = 2'b10,
        REG_SEL  = 2'b11
    } reg_sel_e;

    localparam int B_IRQ  = 7;
    localparam int B_IER  = 6;
    localparam int B_ENA  = 5;
    localparam int B_FIN  = 4;
    localparam int B_BSY  = 3;
    localparam int B_CPOL = 2;
    localparam int B_CPHA = 1;

    typedef struct packed {
        logic ier;
        logic ena;
        logic cpol;
        logic cpha;
    } ctrl_t;

    typedef struct packed {
        logic lead;
        logic trail;
        logic first;
        logic last;
    } edge_t;

    function automatic ctrl_t decode_ctrl(input logic [BUS_W-1:0] b);
        ctrl_t c;
        c.ier  = b[B_IER];
        c.ena  = b[B_ENA];
        c.cpol = b[B_CPOL];
        c.cpha = b[B_CPHA];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input ctrl_t c, input logic irq,
                                                     input logic fin, input logic bsy);
        logic [BUS_W-1:0] s;
        s         = '0;
        s[B_IRQ]  = irq;
        s[B_IER]  = c.ier;
        s[B_ENA]  = c.ena;
        s[B_FIN]  = fin;
        s[B_BSY]  = bsy;
        s[B_CPOL] = c.cpol;
        s[B_CPHA] = c.cpha;
        return s;
    endfunction

endpackage

// File: rtl/spi_regs.sv
module spi_regs
    import spi_bus_pkg::*;
#(
    parameter int SEL_N = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rw,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             busy,
    input  logic             done,
    input  logic [BUS_W-1:0] rx_byte,
    output logic [BUS_W-1:0] rdata,
    output ctrl_t            ctrl,
    output logic [DIV_W-1:0] div,
    output logic [SEL_N-1:0] sel,
    output logic             start,
    output logic             rd_clr,
    output logic             fin,
    output logic             irq
);
    reg_sel_e rsel;
    logic     wr_en;
    logic     rd_en;

    assign rsel   = reg_sel_e'(addr);
    assign wr_en  = !cs_n && !rw;
    assign rd_en  = !cs_n && rw;
    assign start  = wr_en && (rsel == REG_DATA) && ctrl.ena && !busy;
    assign rd_clr = rd_en && (rsel == REG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            div  <= '0;
            sel  <= '0;
        end else if (wr_en) begin
            case (rsel)
                REG_CTRL: ctrl <= decode_ctrl(wdata);
                REG_DIV:  div  <= wdata[DIV_W-1:0];
                REG_SEL:  sel  <= wdata[SEL_N-1:0];
                default:  ;
            endcase
        end
    end

    // completion outranks an acknowledge on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            fin <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (done) begin
                fin <= 1'b1;
                if (ctrl.ier) irq <= 1'b1;
            end else if (rd_clr) begin
                fin <= 1'b0;
                irq <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rsel)
            REG_DATA: rdata = rx_byte;
            REG_CTRL: rdata = pack_status(ctrl, irq, fin, busy);
            REG_DIV:  rdata = BUS_W'(div);
            default:  rdata = BUS_W'(sel);
        endcase
    end

endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq
    import spi_bus_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int NBITS = XFER_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ena,
    input  logic             start,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             sclk,
    output edge_t            edg
);
    localparam int EDGES = 2 * NBITS;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    logic [DIV_W-1:0] cnt;
    logic [EW-1:0]    eidx;
    logic             phase;
    logic             tick;

    assign tick       = busy && (cnt == div);
    assign edg.lead   = tick && !eidx[0];
    assign edg.trail  = tick && eidx[0];
    assign edg.first  = (eidx == '0);
    assign edg.last   = tick && (eidx == LAST);
    assign sclk       = cpol ^ phase;

    always_ff @(posedge clk) begin
        if (rst || !ena) begin
            busy  <= 1'b0;
            cnt   <= '0;
            eidx  <= '0;
            phase <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            eidx  <= '0;
            phase <= 1'b0;
        end else if (busy) begin
            if (tick) begin
                cnt   <= '0;
                phase <= ~phase;
                eidx  <= eidx + 1'b1;
                if (eidx == LAST) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_bus_pkg::*;
#(
    parameter int NBITS = XFER_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] tx_in,
    input  logic             cpha,
    input  edge_t            edg,
    input  logic             miso,
    output logic             mosi,
    output logic [NBITS-1:0] rx_byte
);
    logic [NBITS-1:0] tx_sh;
    logic [NBITS-1:0] rx_sh;
    logic [NBITS-1:0] rx_next;
    logic             do_sample;
    logic             do_shift;

    generate
        if (NBITS > 1) begin : g_wide
            assign rx_next = {rx_sh[NBITS-2:0], miso};
        end else begin : g_one
            assign rx_next = miso;
        end
    endgenerate

    // phase 0: capture on leading, advance on trailing
    // phase 1: advance on every leading edge but the first, capture on trailing
    assign do_sample = cpha ? edg.trail : edg.lead;
    assign do_shift  = cpha ? (edg.lead && !edg.first) : edg.trail;
    assign mosi      = tx_sh[NBITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
        end else if (start) begin
            tx_sh <= tx_in;
            rx_sh <= '0;
        end else begin
            if (do_shift)  tx_sh <= tx_sh << 1;
            if (do_sample) rx_sh <= rx_next;
            if (edg.last)  rx_byte <= do_sample ? rx_next : rx_sh;
        end
    end

endmodule

// File: rtl/spi_bus_master.sv
module spi_bus_master
    import spi_bus_pkg::*;
#(
    parameter int SEL_N = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rw,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq_n,
    input  logic             miso,
    output logic             mosi,
    output logic             sclk,
    output logic [SEL_N-1:0] ss,
    output logic             drive_en
);
    ctrl_t             ctrl;
    logic [DIV_W-1:0]  div;
    logic [SEL_N-1:0]  sel;
    logic              start;
    logic              rd_clr;
    logic              fin;
    logic              irq;
    logic              busy;
    logic              done;
    edge_t             edg;
    logic [XFER_N-1:0] rx_byte;

    assign done     = edg.last;
    assign irq_n    = !irq;
    assign ss       = sel;
    assign drive_en = ctrl.ena;

    spi_regs #(.SEL_N(SEL_N), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rx_byte(rx_byte), .rdata(rdata),
        .ctrl(ctrl), .div(div), .sel(sel), .start(start), .rd_clr(rd_clr),
        .fin(fin), .irq(irq)
    );

    spi_edge_seq #(.DIV_W(DIV_W), .NBITS(XFER_N)) u_seq (
        .clk(clk), .rst(rst), .ena(ctrl.ena), .start(start), .cpol(ctrl.cpol),
        .div(div), .busy(busy), .sclk(sclk), .edg(edg)
    );

    spi_shifter #(.NBITS(XFER_N)) u_shift (
        .clk(clk), .rst(rst), .start(start), .tx_in(wdata), .cpha(ctrl.cpha),
        .edg(edg), .miso(miso), .mosi(mosi), .rx_byte(rx_byte)
    );

endmodule

// File: rtl/spi_bus_master_chk.sv
module spi_bus_master_chk
    import spi_bus_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  busy,
    input logic  sclk,
    input logic  start,
    input logic  done,
    input logic  rd_clr,
    input logic  fin,
    input logic  irq_n,
    input ctrl_t ctrl
);
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == ctrl.cpol));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !done) |=> (!fin && irq_n));

    assert_done_sets_fin_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> fin);

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl.ier) |=> !irq_n);

    assert_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ena |-> !busy);

endmodule

bind spi_bus_master spi_bus_master_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .start(start),
    .done(done), .rd_clr(rd_clr), .fin(fin), .irq_n(irq_n), .ctrl(ctrl)
);

// File: tb/sim_spi_bus_master.sv
module sim_spi_bus_master;
    import spi_bus_pkg::*;

    logic       clk = 1'b0;
    logic       rst, cs_n, rw;
    logic [1:0] addr;
    logic [7:0] wdata, rdata, ss;
    logic       irq_n, miso, mosi, sclk, drive_en;

    always #2.5 clk = ~clk;

    spi_bus_master u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n), .miso(miso), .mosi(mosi), .sclk(sclk),
        .ss(ss), .drive_en(drive_en)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // slave model
    logic [7:0] s_tx = 8'h00;
    logic [7:0] s_rx = 8'h00;
    bit s_first = 1'b1, s_armed = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0;
    assign miso = s_tx[7];

    always @(sclk) if (s_armed) begin
        if (sclk != s_cpol) begin
            if (!s_cpha) s_rx = {s_rx[6:0], mosi};
            else begin
                if (!s_first) s_tx = s_tx << 1;
                s_first = 1'b0;
            end
        end else begin
            if (!s_cpha) s_tx = s_tx << 1;
            else s_rx = {s_rx[6:0], mosi};
        end
    end

    function automatic logic [7:0] ctrl_byte(input bit ier, input bit ena, input bit cpol, input bit cpha);
        logic [7:0] b = 8'h00;
        b[B_IER] = ier; b[B_ENA] = ena; b[B_CPOL] = cpol; b[B_CPHA] = cpha;
        return b;
    endfunction

    function automatic int busy_len(input logic [7:0] dv, input bit poke);
        return 16 * (int'(dv) + 1) - (poke ? 1 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = a; wdata = d;
        @(posedge clk); #1 cs_n = 1'b1; rw = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = a; #1 d = rdata;
        @(posedge clk); #1 cs_n = 1'b1;
    endtask

    task automatic xfer(input bit cpol, input bit cpha, input bit ier,
                        input logic [7:0] dv, input logic [7:0] txb,
                        input logic [7:0] slb, input bit poke);
        int n = 0;
        int tog = 0;
        logic prev;
        logic [7:0] st, rd;
        bus_wr(2'b10, dv);
        bus_wr(2'b01, ctrl_byte(ier, 1'b1, cpol, cpha));
        s_cpol = cpol; s_cpha = cpha; s_tx = slb; s_rx = 8'h00; s_first = 1'b1;
        @(negedge clk);
        chk(sclk == cpol, "R5 idle level before start", sclk, cpol);
        s_armed = 1'b1;
        bus_wr(2'b00, txb);
        if (poke) bus_wr(2'b00, ~txb);
        cs_n = 1'b0; rw = 1'b1; addr = 2'b01; prev = cpol;
        forever begin
            @(negedge clk);
            if (sclk != prev) tog++;
            prev = sclk;
            if (!rdata[B_BSY] || n > 20000) break;
            n++;
        end
        st = rdata;
        cs_n = 1'b1; s_armed = 1'b0;
        chk(n == busy_len(dv, poke), poke ? "R9 busy length with ignored write" : "R3 busy length",
            n, busy_len(dv, poke));
        chk(tog == 16, "R5 sclk toggles", tog, 16);
        chk(sclk == cpol, "R5 rest level after", sclk, cpol);
        chk(st[B_FIN] == 1'b1, "R6 done flag", st[B_FIN], 1);
        chk(st[B_IRQ] == ier, "R7 irq status", st[B_IRQ], ier);
        chk(irq_n == !ier, "R7 irq pin", irq_n, !ier);
        chk(s_rx == txb, poke ? "R9 slave got original" : "R4 slave received", s_rx, txb);
        bus_rd(2'b00, rd);
        chk(rd == slb, "R4 received byte", rd, slb);
        bus_rd(2'b01, st);
        chk(st[B_FIN] == 1'b0 && st[B_IRQ] == 1'b0 && irq_n == 1'b1,
            "R6 data read clears flags", {st[B_IRQ], st[B_FIN], irq_n}, 3'b001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, last_rx;
        void'($urandom(32'd5150));
        rst = 1'b1; cs_n = 1'b1; rw = 1'b1; addr = 2'b00; wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2 reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), v);
            chk(v == 8'h00, "R2 register after reset", v, 0);
        end
        chk(irq_n == 1'b1 && drive_en == 1'b0 && ss == 8'h00, "R2 pins after reset",
            {irq_n, drive_en, ss}, 10'h200);

        // R1 / R10 readback
        bus_wr(2'b10, 8'h5A); bus_rd(2'b10, v);
        chk(v == 8'h5A, "R1 divisor readback", v, 8'h5A);
        bus_wr(2'b11, 8'hC3); bus_rd(2'b11, v);
        chk(v == 8'hC3, "R1 select readback", v, 8'hC3);
        chk(ss == 8'hC3, "R10 select pins", ss, 8'hC3);
        bus_wr(2'b01, ctrl_byte(1, 1, 1, 1)); bus_rd(2'b01, v);
        chk(v == 8'h66, "R1 control in status", v, 8'h66);
        chk(drive_en == 1'b1, "R8 drive enabled", drive_en, 1);
        bus_wr(2'b01, 8'h00);

        // directed corners
        xfer(0, 0, 0, 8'd0,   8'hA5, 8'h3C, 0);
        xfer(1, 1, 1, 8'd255, 8'h81, 8'h7E, 0);
        xfer(0, 1, 1, 8'd2,   8'hF0, 8'h0F, 1);
        xfer(1, 0, 0, 8'd0,   8'h01, 8'h80, 1);

        // constrained random
        for (int i = 0; i < 14; i++) begin
            xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 8'($urandom % 6),
                 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end
        bus_wr(2'b11, 8'h96);
        chk(ss == 8'h96, "R10 select pins after traffic", ss, 8'h96);

        // R8 disabled interface
        bus_rd(2'b00, last_rx);
        bus_wr(2'b01, ctrl_byte(1, 0, 0, 0));
        chk(drive_en == 1'b0, "R8 drive released", drive_en, 0);
        bus_wr(2'b00, 8'h3C);
        bus_rd(2'b01, v);
        chk(v[B_BSY] == 1'b0 && v[B_FIN] == 1'b0, "R8 no transfer when disabled", v, 8'h40);
        repeat (40) @(posedge clk);
        bus_rd(2'b00, v);
        chk(v == last_rx, "R8 received byte unchanged", v, last_rx);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule